// File: doc/BRIEF.md
# PWM Generator Status and Trigger Register

This block is the 32-bit status and control word of one PWM generator, reached over a simple register bus. The bus offers a select, a write flag, an address, byte enables and write data. Reads return data combinationally. Five condition inputs drive the word: sync, fault 1, fault 2, current limit and feed-forward. For each input the word holds a sticky event flag and a live level bit. Software clears an event flag by writing a one to it.

Three write-one strobes act on the generator core. One starts a PWM cycle and one stops it, and the TRIG status bit records the result. The third requests a data-register update. That request raises UPDATE, and UPDATE locks the user data registers until the core reports that the update is done. The core also supplies a time-base capture flag, a trigger-value capture flag, the push-pull steering phase and the center-aligned half-cycle phase, and the block reflects all of these in the word.

Top module: `pwm_stat_reg`

## Requirements
- R1: After reset the word reads 0x0000_0000, with the condition inputs, `steer_i` and `cahalf_i` all low, and `trig_o` and `upd_lock_o` are 0.
- R2: Condition input k (0 feed-forward, 1 current limit, 2 fault 1, 3 fault 2, 4 sync) sets sticky flag bit 16+k on the clock edge where it is first seen high while `en_i` is high.
- R3: A condition input that is already high when `en_i` rises sets its flag bit on the first edge at which `en_i` is seen high.
- R4: Event flags stay set until software writes 1 to the bit with `be_i[2]` set. Writing 0 to the bit, or writing with `be_i[2]` clear, leaves the flag unchanged.
- R5: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: Bits 12..8 show the live level of condition inputs 4..0 without delay.
- R7: Writing 1 to bit 7 with `be_i[0]` set sets TRIG (bit 0 and `trig_o`) and pulses `start_o`. Writing 1 to bit 6 clears TRIG and pulses `stop_o`. If both are written in the same write, the clear wins. Bits 7, 6 and 3 always read 0.
- R8: A pulse on `cyc_done_i` clears TRIG, unless a start is written in the same cycle.
- R9: Writing 1 to bit 3 with `be_i[0]` set sets UPDATE (bit 4) and `upd_lock_o`. A pulse on `upd_done_i` clears both, unless a new request arrives in the same cycle.
- R10: A pulse on `tb_cap_i` sets CAP (bit 5) and a pulse on `trig_cap_i` sets bit 13. Each stays set until a write-one clear (`be_i[0]` for bit 5, `be_i[1]` for bit 13).
- R11: Bit 2 follows `steer_i` and bit 1 follows `cahalf_i`. Undefined bits read 0. An access with `addr_i` different from `REG_ADDR` reads 0 and changes nothing.
- R12: While `en_i` is low, no event flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| cond_i | input | 5 | Condition levels: sync, flt2, flt1, climit, ffwd (bit 4..0) |
| tb_cap_i | input | 1 | Time-base value captured pulse |
| trig_cap_i | input | 1 | Trigger value captured pulse |
| steer_i | input | 1 | Push-pull second-cycle phase |
| cahalf_i | input | 1 | Center-aligned second-half phase |
| cyc_done_i | input | 1 | PWM cycle complete pulse |
| upd_done_i | input | 1 | Data update applied pulse |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Bus write |
| addr_i | input | 8 | Bus address |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| trig_o | output | 1 | Generator triggered |
| upd_lock_o | output | 1 | User data registers write-locked |
| start_o | output | 1 | Cycle start strobe |
| stop_o | output | 1 | Cycle stop strobe |

## Verification
The hardest case to reach is a write-one clear that lands in the same cycle as a fresh rising edge on the condition it clears. The clock edge has to see both the clear and the edge together. To get there, the bench applies each vector's condition levels and its write in one step before a single edge, so a vector can raise an input and clear that input's flag at once. Two more cases need an ordered sequence: enabling the block with an input already high, and an input that rises while the block is disabled.

// File: rtl/pwm_stat_pkg.sv
package pwm_stat_pkg;
  localparam int N_COND     = 5;
  localparam int DATA_W     = 32;
  localparam int BE_W       = DATA_W / 8;
  localparam int EVT_LSB    = 16;
  localparam int ACT_LSB    = 8;
  localparam int CAPTR_BIT  = 13;
  localparam int TRSET_BIT  = 7;
  localparam int TRCLR_BIT  = 6;
  localparam int CAP_BIT    = 5;
  localparam int UPD_BIT    = 4;
  localparam int UPDREQ_BIT = 3;
  localparam int STEER_BIT  = 2;
  localparam int CAHALF_BIT = 1;
  localparam int TRIG_BIT   = 0;

  typedef struct packed {
    logic [N_COND-1:0] evt_clr;
    logic              captr_clr;
    logic              cap_clr;
    logic              trset;
    logic              trclr;
    logic              updreq;
  } wr_cmd_t;
endpackage

// File: rtl/pwm_bus_dec.sv
module pwm_bus_dec
  import pwm_stat_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output wr_cmd_t           cmd_o
);
  localparam int EVT_BYTE = EVT_LSB / 8;
  localparam int CPT_BYTE = CAPTR_BIT / 8;
  localparam int CTL_BYTE = 0;

  logic wr_hit;
  logic unused_wbits;

  assign hit_o  = sel_i && (addr_i == REG_ADDR);
  assign wr_hit = hit_o && wr_i;

  always_comb begin
    cmd_o           = '0;
    if (wr_hit) begin
      if (be_i[EVT_BYTE]) cmd_o.evt_clr   = wdata_i[EVT_LSB +: N_COND];
      if (be_i[CPT_BYTE]) cmd_o.captr_clr = wdata_i[CAPTR_BIT];
      if (be_i[CTL_BYTE]) begin
        cmd_o.cap_clr = wdata_i[CAP_BIT];
        cmd_o.trset   = wdata_i[TRSET_BIT];
        cmd_o.trclr   = wdata_i[TRCLR_BIT];
        cmd_o.updreq  = wdata_i[UPDREQ_BIT];
      end
    end
  end

  assign unused_wbits = ^{wdata_i[DATA_W-1:EVT_LSB+N_COND], wdata_i[15:14],
                          wdata_i[12:8], wdata_i[4], wdata_i[2:0], be_i[3]};
endmodule

// File: rtl/pwm_w1c_bit.sv
module pwm_w1c_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // hardware set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R5
endmodule

// File: rtl/pwm_evt_flags.sv
module pwm_evt_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic         en_q;
  logic [N-1:0] cond_q;
  logic [N-1:0] set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cond_q <= '0;
    end else begin
      en_q   <= en_i;
      cond_q <= cond_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    // rising edge, or level already high when enable rises
    assign set[i] = en_i && cond_i[i] && (!cond_q[i] || !en_q);

    pwm_w1c_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set[i]),
      .clr_i  (clr_i[i]),
      .q_o    (flag_o[i])
    );

    AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && cond_i[i] && !cond_q[i] |=> flag_o[i]); // R2
    AST_ENABLE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && !en_q && cond_i[i] |=> flag_o[i]); // R3
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o[i] && !clr_i[i] |=> flag_o[i]); // R4
    AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i && !flag_o[i] |=> !flag_o[i]); // R12
  end
endmodule

// File: rtl/pwm_trig_ctrl.sv
module pwm_trig_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trset_i,
  input  logic trclr_i,
  input  logic cyc_done_i,
  input  logic updreq_i,
  input  logic upd_done_i,
  output logic trig_o,
  output logic upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o <= 1'b0;
      upd_o  <= 1'b0;
    end else begin
      if (trclr_i)         trig_o <= 1'b0;
      else if (trset_i)    trig_o <= 1'b1;
      else if (cyc_done_i) trig_o <= 1'b0;

      if (updreq_i)        upd_o  <= 1'b1;
      else if (upd_done_i) upd_o  <= 1'b0;
    end
  end

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trclr_i |=> !trig_o); // R7
  AST_START_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trset_i && !trclr_i |=> trig_o); // R7
  AST_CYC_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_done_i && !trset_i |=> !trig_o); // R8
  AST_UPD_REQ_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    updreq_i |=> upd_o); // R9
  AST_UPD_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i && !updreq_i |=> !upd_o); // R9
endmodule

// File: rtl/pwm_stat_reg.sv
module pwm_stat_reg
  import pwm_stat_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [N_COND-1:0] cond_i,
  input  logic              tb_cap_i,
  input  logic              trig_cap_i,
  input  logic              steer_i,
  input  logic              cahalf_i,
  input  logic              cyc_done_i,
  input  logic              upd_done_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              trig_o,
  output logic              upd_lock_o,
  output logic              start_o,
  output logic              stop_o
);
  wr_cmd_t           cmd;
  logic              hit;
  logic [N_COND-1:0] evt_q;
  logic              cap_q;
  logic              captr_q;
  logic              trig_q;
  logic              upd_q;
  logic [DATA_W-1:0] word;

  pwm_bus_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .hit_o   (hit),
    .cmd_o   (cmd)
  );

  pwm_evt_flags #(.N(N_COND)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .cond_i (cond_i),
    .clr_i  (cmd.evt_clr),
    .flag_o (evt_q)
  );

  pwm_w1c_bit u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tb_cap_i),
    .clr_i  (cmd.cap_clr),
    .q_o    (cap_q)
  );

  pwm_w1c_bit u_captr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig_cap_i),
    .clr_i  (cmd.captr_clr),
    .q_o    (captr_q)
  );

  pwm_trig_ctrl u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trset_i    (cmd.trset),
    .trclr_i    (cmd.trclr),
    .cyc_done_i (cyc_done_i),
    .updreq_i   (cmd.updreq),
    .upd_done_i (upd_done_i),
    .trig_o     (trig_q),
    .upd_o      (upd_q)
  );

  // strobe bits 7, 6, 3 are never driven: they read 0
  always_comb begin
    word                        = '0;
    word[EVT_LSB +: N_COND]     = evt_q;
    word[ACT_LSB +: N_COND]     = cond_i;
    word[CAPTR_BIT]             = captr_q;
    word[CAP_BIT]               = cap_q;
    word[UPD_BIT]               = upd_q;
    word[STEER_BIT]             = steer_i;
    word[CAHALF_BIT]            = cahalf_i;
    word[TRIG_BIT]              = trig_q;
  end

  assign rdata_o    = hit ? word : '0;
  assign trig_o     = trig_q;
  assign upd_lock_o = upd_q;
  assign start_o    = cmd.trset && !cmd.trclr;
  assign stop_o     = cmd.trclr;

  AST_CAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q && !cmd.cap_clr |=> cap_q); // R10
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o)); // R7
endmodule

// File: tb/pwm_stat_reg_tb.sv
module pwm_stat_reg_tb;
  localparam logic [7:0] RA = 8'h3C;
  // {cond[4:0], wr, be[3:0], wdata[31:0], expected[31:0]}
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {5'b00001, 1'b0, 4'h0, 32'h0, 32'h0001_0100},  // R2 R6
    {5'b00000, 1'b0, 4'h0, 32'h0, 32'h0001_0000},  // R4
    {5'b10100, 1'b0, 4'h0, 32'h0, 32'h0015_1400},  // R2 R6
    {5'b10100, 1'b1, 4'h4, 32'h0001_0000, 32'h0014_1400}, // R4 clear
    {5'b00000, 1'b1, 4'h3, 32'h0014_0000, 32'h0014_0000}, // R4 be gate
    {5'b00000, 1'b1, 4'h4, 32'h0014_0000, 32'h0000_0000}, // R4
    {5'b00000, 1'b1, 4'h1, 32'h0000_0080, 32'h0000_0001}, // R7
    {5'b00000, 1'b1, 4'h1, 32'h0000_0008, 32'h0000_0011}, // R9
    {5'b00000, 1'b1, 4'h1, 32'h0000_00C0, 32'h0000_0010}, // R7 both
    {5'b01000, 1'b1, 4'h4, 32'h0008_0000, 32'h0008_0810}  // R5
  };

  logic        clk = 0, rst_ni = 0, en = 0;
  logic [4:0]  cond = 0;
  logic        tb_cap = 0, trig_cap = 0, steer = 0, cahalf = 0;
  logic        cyc_done = 0, upd_done = 0;
  logic        sel = 1, wr = 0;
  logic [7:0]  addr = RA;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        trig, upd_lock, start, stop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_stat_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cond_i(cond),
    .tb_cap_i(tb_cap), .trig_cap_i(trig_cap), .steer_i(steer), .cahalf_i(cahalf),
    .cyc_done_i(cyc_done), .upd_done_i(upd_done),
    .sel_i(sel), .wr_i(wr), .addr_i(addr), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata), .trig_o(trig), .upd_lock_o(upd_lock),
    .start_o(start), .stop_o(stop)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive after falling edge, clock once, drop write and pulses
  task automatic step(logic [4:0] c, logic w, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    cond = c; wr = w; be = b; wdata = d;
    @(posedge clk); #1;
    wr = 0; be = 0; wdata = 0;
    tb_cap = 0; trig_cap = 0; cyc_done = 0; upd_done = 0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1;
    @(negedge clk);
    chk("R1 word", rdata, 32'h0);
    chk("R1 outs", {30'h0, trig, upd_lock}, 32'h0);
    en = 1;
    step(5'b0, 0, 4'h0, 0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][73:69], VEC[i][68], VEC[i][67:64], VEC[i][63:32]);
      chk($sformatf("vec%0d R2-set", i), rdata, VEC[i][31:0]);
    end
    // clean up: clear all flags, stop, finish update
    upd_done = 1;
    step(5'b0, 1, 4'hF, 32'h001F_2060);
    chk("R9 upd_done", {31'h0, upd_lock}, 32'h0);
    chk("R4 clear all", rdata, 32'h0);

    // R12 and R3
    en = 0;
    step(5'b00010, 0, 4'h0, 0);
    chk("R12 disabled", rdata, 32'h0000_0200);
    en = 1;
    step(5'b00010, 0, 4'h0, 0);
    chk("R3 enable-high", rdata, 32'h0002_0200);
    step(5'b00000, 1, 4'h4, 32'h0002_0000);

    // R7 start strobe visible during write, R8 cycle done
    @(negedge clk);
    wr = 1; be = 4'h1; wdata = 32'h80; #1;
    chk("R7 start_o", {31'h0, start}, 32'h1);
    @(posedge clk); #1; wr = 0; be = 0; wdata = 0;
    chk("R7 trig_o", {31'h0, trig}, 32'h1);
    cyc_done = 1;
    step(5'b0, 0, 4'h0, 0);
    chk("R8 cyc_done", rdata, 32'h0);
    // R8 start beats cycle done
    cyc_done = 1;
    step(5'b0, 1, 4'h1, 32'h80);
    chk("R8 start wins", rdata, 32'h1);
    @(negedge clk);
    wr = 1; be = 4'h1; wdata = 32'h40; #1;
    chk("R7 stop_o", {30'h0, stop, start}, 32'h2);
    @(posedge clk); #1; wr = 0; be = 0; wdata = 0;
    chk("R7 stopped", rdata, 32'h0);

    // R9 request beats done
    step(5'b0, 1, 4'h1, 32'h08);
    upd_done = 1;
    step(5'b0, 1, 4'h1, 32'h08);
    chk("R9 req wins", {31'h0, upd_lock}, 32'h1);
    upd_done = 1;
    step(5'b0, 0, 4'h0, 0);
    chk("R9 cleared", rdata, 32'h0);

    // R10 capture flags
    tb_cap = 1; trig_cap = 1;
    step(5'b0, 0, 4'h0, 0);
    step(5'b0, 0, 4'h0, 0);
    chk("R10 set sticky", rdata, 32'h0000_2020);
    step(5'b0, 1, 4'h1, 32'h2020);
    chk("R10 cap clr", rdata, 32'h0000_2000);
    step(5'b0, 1, 4'h2, 32'h2020);
    chk("R10 captr clr", rdata, 32'h0);

    // R11 mirrors and address decode
    steer = 1; cahalf = 1;
    @(negedge clk);
    chk("R11 phases", rdata, 32'h0000_0006);
    steer = 0; cahalf = 0;
    addr = 8'h40;
    step(5'b00001, 1, 4'hF, 32'h0000_0088);
    chk("R11 other addr read", rdata, 32'h0);
    addr = RA;
    #1;
    chk("R11 other addr write", rdata, 32'h0001_0100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule